// File: doc/BRIEF.md
# LCD Frame DMA Channel Sequencer

This block runs the per-frame fetch schedule of a display controller that owns several descriptor channels, the upper two of which feed overlay planes. Each channel presents a source address, a command word and an active flag. On every frame tick, if the controller is switched on, the sequencer visits the channels one by one from channel 0 upward. It checks each active channel's source address against a legal memory window. It then issues a single read request, which is either a palette load or a frame fetch, and waits for the memory side to finish before it moves on.

A small register bank holds a control word, a status word and an interrupt mask. Status bits record start-of-frame, end-of-frame and bus error per channel, and a last-frame-done flag. Software clears them by writing ones. A disable request is honoured only when a pass over the channels finishes. The pass then clears the enable bit and raises the done flag. Every completed pass emits a one-cycle vsync pulse and re-evaluates the interrupt line.

Top module: `lcd_frame_dma`

## Requirements
- R1: A frame tick while control bit 0 (enable) is clear, or while a pass is already running, starts nothing: no memory request, no vsync and no status change.
- R2: In a pass, active channels are served in ascending index order, and channels whose active flag is low are passed over.
- R3: An active channel with source address zero sets its bus-error status bit (status bit 2*NCH+ch) and issues no request.
- R4: An active channel whose nonzero source address is below WIN_LO or above WIN_HI sets its bus-error bit and issues no request.
- R5: When command bit 16 is set, the request is a palette load (mem_pal high) with length equal to command bits [LEN_W-1:0], and neither start-of-frame nor end-of-frame is set for that channel.
- R6: For a frame fetch, start-of-frame (status bit ch) is set in the cycle the request is issued, and end-of-frame (status bit NCH+ch) is set when mem_done is accepted.
- R7: overlay_on is high whenever channel 2 or channel 3 is active.
- R8: When the palette format field (control bits [3:2]) differs from the format last applied, pal_reparse pulses together with the next frame-fetch request. A palette load applies the current format.
- R9: If control bit 1 (disable) is set when a pass ends, the enable bit is cleared and the done status bit (bit 3*NCH) is set.
- R10: Each pass that starts ends with vsync high for exactly one cycle. irq is the OR of status AND mask, and it is updated at pass end and after any write to the status or mask register.
- R11: Status bits are write-1-to-clear (register address 1), and a hardware set in the same cycle as a clear leaves the bit set. Address 0 is control and address 2 is mask.
- R12: Exactly one single-cycle request is issued per transfer, and no further request is made until mem_done has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | Start-of-frame trigger |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ch_active | input | NCH | Per-channel active flag |
| ch_src | input | NCH*AW | Per-channel source address, channel 0 in the low bits |
| ch_cmd | input | NCH*32 | Per-channel command word |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Request address |
| mem_len | output | LEN_W | Request length |
| mem_pal | output | 1 | Request is a palette load |
| mem_done | input | 1 | Transfer-finished handshake |
| pal_reparse | output | 1 | Palette must be reinterpreted (with request) |
| overlay_on | output | 1 | An overlay channel is active |
| irq | output | 1 | Interrupt output |
| vsync | output | 1 | One-cycle end-of-pass pulse |

## Verification
Software's write-1-to-clear of a status bit and the sequencer's setting of that same bit can land on the same clock edge. The bench provokes this by writing the clear for channel 0's start-of-frame bit in the cycle right after the frame tick, which is when channel 0 is examined and its request is issued. After the pass, it judges the outcome by reading the status register, where the bit must still be set. The bench also places a disable request before a pass and checks that the enable clear and the done flag arrive only at the end of that pass.

// File: rtl/lcd_dma_pkg.sv
package lcd_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } walk_st_e;

    localparam int CTRL_EN     = 0;
    localparam int CTRL_DIS    = 1;
    localparam int CTRL_FMT_LO = 2;
    localparam int CTRL_W      = 4;
    localparam int CMD_PAL     = 16;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_MASK = 2'd2;

endpackage

// File: rtl/lcd_dma_addr_chk.sv
module lcd_dma_addr_chk #(
    parameter int            NCH    = 4,
    parameter int            AW     = 32,
    parameter logic [AW-1:0] WIN_LO = 32'h1000_0000,
    parameter logic [AW-1:0] WIN_HI = 32'h1FFF_FFFF
) (
    input  logic [NCH*AW-1:0] src_flat,
    output logic [NCH-1:0]    src_ok
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic [AW-1:0] s;
        assign s         = src_flat[g*AW +: AW];
        assign src_ok[g] = (s != '0) && (s >= WIN_LO) && (s <= WIN_HI);
    end

endmodule

// File: rtl/lcd_dma_regs.sv
module lcd_dma_regs
    import lcd_dma_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    input  logic [NCH-1:0] sof_set,
    input  logic [NCH-1:0] eof_set,
    input  logic [NCH-1:0] berr_set,
    input  logic           done_set,
    input  logic           pass_end,
    output logic           en,
    output logic           dis,
    output logic [1:0]     fmt,
    output logic           irq
);

    localparam int STW = 3*NCH + 1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [STW-1:0]    status;
        logic [STW-1:0]    mask;
        logic              irq;
    } regs_s;

    regs_s q_q, n_d;
    logic [STW-1:0] hw_set;
    logic stat_wr, mask_wr, ctrl_wr;

    assign hw_set  = {done_set, berr_set, eof_set, sof_set};
    assign ctrl_wr = wr_en && (addr == RA_CTRL);
    assign stat_wr = wr_en && (addr == RA_STAT);
    assign mask_wr = wr_en && (addr == RA_MASK);

    always_comb begin
        n_d = q_q;
        if (ctrl_wr) n_d.ctrl = wdata[CTRL_W-1:0];
        if (stat_wr) n_d.status = q_q.status & ~wdata[STW-1:0];
        if (mask_wr) n_d.mask = wdata[STW-1:0];
        n_d.status = n_d.status | hw_set;
        if (done_set) n_d.ctrl[CTRL_EN] = 1'b0;
        if (pass_end || stat_wr || mask_wr)
            n_d.irq = |(n_d.status & n_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= n_d;
    end

    always_comb begin
        case (addr)
            RA_CTRL: rdata = 32'(q_q.ctrl);
            RA_STAT: rdata = 32'(q_q.status);
            RA_MASK: rdata = 32'(q_q.mask);
            default: rdata = '0;
        endcase
    end

    assign en  = q_q.ctrl[CTRL_EN];
    assign dis = q_q.ctrl[CTRL_DIS];
    assign fmt = q_q.ctrl[CTRL_FMT_LO +: 2];
    assign irq = q_q.irq;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((q_q.status & $past(hw_set)) == $past(hw_set))); // R11

    AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> (!q_q.ctrl[CTRL_EN] && q_q.status[STW-1])); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_end || stat_wr || mask_wr) |=> $stable(q_q.irq)); // R10

endmodule

// File: rtl/lcd_dma_walker.sv
module lcd_dma_walker
    import lcd_dma_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 32,
    parameter int LEN_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_tick,
    input  logic            en,
    input  logic            dis,
    input  logic [1:0]      fmt,
    input  logic [NCH-1:0]  ch_active,
    input  logic [NCH*AW-1:0] ch_src,
    input  logic [NCH*32-1:0] ch_cmd,
    input  logic [NCH-1:0]  src_ok,
    input  logic            mem_done,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic [LEN_W-1:0] mem_len,
    output logic            mem_pal,
    output logic            pal_reparse,
    output logic            vsync,
    output logic [NCH-1:0]  sof_set,
    output logic [NCH-1:0]  eof_set,
    output logic [NCH-1:0]  berr_set,
    output logic            done_set,
    output logic            pass_end
);

    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    typedef struct packed {
        walk_st_e       st;
        logic [CW-1:0]  ch;
        logic           req;
        logic [AW-1:0]  addr;
        logic [LEN_W-1:0] len;
        logic           pal;
        logic           reparse;
        logic [1:0]     fmt_seen;
        logic           vsync;
    } walk_s;

    walk_s q_q, n_d;
    logic [AW-1:0] cur_src;
    logic [31:0]   cur_cmd;
    logic          step;

    assign cur_src = ch_src[int'(q_q.ch)*AW +: AW];
    assign cur_cmd = ch_cmd[int'(q_q.ch)*32 +: 32];

    always_comb begin
        n_d        = q_q;
        n_d.req    = 1'b0;
        n_d.reparse = 1'b0;
        n_d.vsync  = 1'b0;
        sof_set    = '0;
        eof_set    = '0;
        berr_set   = '0;
        done_set   = 1'b0;
        pass_end   = 1'b0;
        step       = 1'b0;
        case (q_q.st)
            ST_IDLE: begin
                if (frame_tick && en) begin
                    n_d.st = ST_SCAN;
                    n_d.ch = '0;
                end
            end
            ST_SCAN: begin
                if (!ch_active[q_q.ch]) begin
                    step = 1'b1;
                end else if (!src_ok[q_q.ch]) begin
                    berr_set[q_q.ch] = 1'b1;
                    step = 1'b1;
                end else begin
                    n_d.req  = 1'b1;
                    n_d.addr = cur_src;
                    n_d.len  = cur_cmd[LEN_W-1:0];
                    n_d.pal  = cur_cmd[CMD_PAL];
                    n_d.st   = ST_WAIT;
                    if (cur_cmd[CMD_PAL]) begin
                        n_d.fmt_seen = fmt;
                    end else begin
                        sof_set[q_q.ch] = 1'b1;
                        if (fmt != q_q.fmt_seen) begin
                            n_d.reparse  = 1'b1;
                            n_d.fmt_seen = fmt;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (mem_done) begin
                    if (!q_q.pal) eof_set[q_q.ch] = 1'b1;
                    step = 1'b1;
                end
            end
            default: begin
                pass_end  = 1'b1;
                n_d.vsync = 1'b1;
                done_set  = dis;
                n_d.st    = ST_IDLE;
            end
        endcase
        if (step) begin
            if (q_q.ch == LAST) begin
                n_d.st = ST_FINISH;
            end else begin
                n_d.ch = q_q.ch + 1'b1;
                n_d.st = ST_SCAN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= n_d;
    end

    assign mem_req     = q_q.req;
    assign mem_addr    = q_q.addr;
    assign mem_len     = q_q.len;
    assign mem_pal     = q_q.pal;
    assign pal_reparse = q_q.reparse;
    assign vsync       = q_q.vsync;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R12

    AST_REQ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_WAIT && !mem_done) |=> !mem_req); // R12

    AST_BERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_set != '0) |=> !mem_req); // R3

    AST_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_IDLE && !en) |=> (q_q.st == ST_IDLE)); // R1

    AST_VSYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !vsync); // R10

    AST_REPARSE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pal_reparse |-> (mem_req && !mem_pal)); // R8

endmodule

// File: rtl/lcd_frame_dma.sv
module lcd_frame_dma
    import lcd_dma_pkg::*;
#(
    parameter int            NCH    = 4,
    parameter int            AW     = 32,
    parameter int            LEN_W  = 12,
    parameter logic [AW-1:0] WIN_LO = 32'h1000_0000,
    parameter logic [AW-1:0] WIN_HI = 32'h1FFF_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_tick,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NCH-1:0]     ch_active,
    input  logic [NCH*AW-1:0]  ch_src,
    input  logic [NCH*32-1:0]  ch_cmd,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    output logic [LEN_W-1:0]   mem_len,
    output logic               mem_pal,
    input  logic               mem_done,
    output logic               pal_reparse,
    output logic               overlay_on,
    output logic               irq,
    output logic               vsync
);

    logic [NCH-1:0] src_ok, sof_set, eof_set, berr_set;
    logic en, dis, done_set, pass_end;
    logic [1:0] fmt;

    lcd_dma_addr_chk #(.NCH(NCH), .AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (
        .src_flat (ch_src),
        .src_ok   (src_ok)
    );

    lcd_dma_regs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .sof_set  (sof_set),
        .eof_set  (eof_set),
        .berr_set (berr_set),
        .done_set (done_set),
        .pass_end (pass_end),
        .en       (en),
        .dis      (dis),
        .fmt      (fmt),
        .irq      (irq)
    );

    lcd_dma_walker #(.NCH(NCH), .AW(AW), .LEN_W(LEN_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_tick  (frame_tick),
        .en          (en),
        .dis         (dis),
        .fmt         (fmt),
        .ch_active   (ch_active),
        .ch_src      (ch_src),
        .ch_cmd      (ch_cmd),
        .src_ok      (src_ok),
        .mem_done    (mem_done),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_len     (mem_len),
        .mem_pal     (mem_pal),
        .pal_reparse (pal_reparse),
        .vsync       (vsync),
        .sof_set     (sof_set),
        .eof_set     (eof_set),
        .berr_set    (berr_set),
        .done_set    (done_set),
        .pass_end    (pass_end)
    );

    if (NCH >= 4) begin : g_ovl
        assign overlay_on = ch_active[2] | ch_active[3];
    end else begin : g_no_ovl
        assign overlay_on = 1'b0;
    end

endmodule

// File: tb/lcd_frame_dma_test.sv
module lcd_frame_dma_test;

    localparam int NCH = 4;
    localparam int AW  = 32;
    localparam int LW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] ch_active = '0;
    logic [NCH*AW-1:0] ch_src = '0;
    logic [NCH*32-1:0] ch_cmd = '0;
    logic mem_req, mem_pal, mem_done = 1'b0, pal_reparse, overlay_on, irq, vsync;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_len;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [AW-1:0] log_addr [16];
    logic [LW-1:0] log_len [16];
    logic          log_pal [16];
    logic          log_rep [16];
    int            log_n = 0;
    int            overlap = 0;
    int            vs_cycles = 0;

    always #4 clk = ~clk;

    lcd_frame_dma uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ch_active(ch_active), .ch_src(ch_src), .ch_cmd(ch_cmd),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_pal(mem_pal),
        .mem_done(mem_done), .pal_reparse(pal_reparse), .overlay_on(overlay_on),
        .irq(irq), .vsync(vsync)
    );

    // memory responder: done two cycles after each request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                if (log_n < 16) begin
                    log_addr[log_n] = mem_addr;
                    log_len[log_n]  = mem_len;
                    log_pal[log_n]  = mem_pal;
                    log_rep[log_n]  = pal_reparse;
                end
                log_n++;
                @(negedge clk);
                if (mem_req) overlap++;
                @(negedge clk);
                if (mem_req) overlap++;
                mem_done = 1'b1;
                @(negedge clk);
                mem_done = 1'b0;
            end
        end
    end

    always @(negedge clk) if (vsync) vs_cycles++;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_ch(input int i, input logic act, input logic [31:0] src, input logic [31:0] cmd);
        ch_active[i] = act;
        ch_src[i*AW +: AW] = src;
        ch_cmd[i*32 +: 32] = cmd;
    endtask

    task automatic clear_all();
        reg_write(2'd1, 32'hFFFF_FFFF);
        log_n = 0; overlap = 0; vs_cycles = 0;
    endtask

    task automatic run_frame();
        int n;
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        n = 0;
        while (!vsync && n < 200) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(2'd0, d); check(d == 0, "R11 reset ctrl", d, 0);
        reg_read(2'd1, d); check(d == 0, "R11 reset status", d, 0);
        check(!irq && !vsync && !mem_req, "R10 reset outputs", {irq, vsync, mem_req}, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        clear_all();
        set_ch(0, 1, 32'h1000_0000, 32'h10);
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
        repeat (20) @(negedge clk);
        check(log_n == 0, "R1 no request when off", log_n, 0);
        check(vs_cycles == 0, "R1 no vsync when off", vs_cycles, 0);
        reg_read(2'd1, d); check(d == 0, "R1 status unchanged", d, 0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        clear_all();
        set_ch(0, 1, 32'h1000_0100, 32'h20);
        set_ch(1, 1, 32'h1000_0200, 32'h21);
        set_ch(2, 0, 32'h1000_0300, 32'h22);
        set_ch(3, 1, 32'h1000_0400, 32'h23);
        reg_write(2'd0, 32'h1);
        run_frame();
        check(log_n == 3, "R2 request count", log_n, 3);
        check(log_addr[0] == 32'h1000_0100, "R2 first channel", log_addr[0], 32'h1000_0100);
        check(log_addr[1] == 32'h1000_0200, "R2 second channel", log_addr[1], 32'h1000_0200);
        check(log_addr[2] == 32'h1000_0400, "R2 skip inactive ch2", log_addr[2], 32'h1000_0400);
        check(log_len[2] == 12'h23, "R6 fetch length", log_len[2], 12'h23);
        check(overlap == 0, "R12 no request while waiting", overlap, 0);
        reg_read(2'd1, d);
        check(d == 32'h0000_00BB, "R6 sof and eof bits", d, 32'hBB);
        check(vs_cycles == 1, "R10 vsync one cycle", vs_cycles, 1);
        check(overlay_on == 1'b1, "R7 overlay with ch3", overlay_on, 1);
        ch_active = 4'b0011; #1;
        check(overlay_on == 1'b0, "R7 no overlay", overlay_on, 0);
        ch_active = 4'b0100; #1;
        check(overlay_on == 1'b1, "R7 overlay with ch2", overlay_on, 1);
    endtask

    task automatic t_berr();
        logic [31:0] d;
        clear_all();
        ch_active = '0;
        set_ch(0, 1, 32'h0, 32'h10);
        set_ch(1, 1, 32'h2000_0000, 32'h10);
        set_ch(2, 1, 32'h1FFF_FF00, 32'h10);
        run_frame();
        check(log_n == 1, "R3 R4 only valid channel fetched", log_n, 1);
        check(log_addr[0] == 32'h1FFF_FF00, "R4 valid address used", log_addr[0], 32'h1FFF_FF00);
        reg_read(2'd1, d);
        check(d[11:8] == 4'b0011, "R3 R4 bus error bits", d[11:8], 4'b0011);
        check(d[7:0] == 8'h44, "R6 frame bits of ch2", d[7:0], 8'h44);
    endtask

    task automatic t_reparse();
        clear_all();
        ch_active = '0;
        set_ch(0, 1, 32'h1000_0000, 32'h30);
        reg_write(2'd0, 32'h1 | (32'd1 << 2));
        run_frame();
        check(log_n == 1 && log_rep[0] == 1'b1, "R8 reparse on format change", log_rep[0], 1);
        log_n = 0;
        run_frame();
        check(log_n == 1 && log_rep[0] == 1'b0, "R8 no reparse same format", log_rep[0], 0);
    endtask

    task automatic t_palette();
        logic [31:0] d;
        clear_all();
        ch_active = '0;
        set_ch(0, 1, 32'h1000_8000, (32'd1 << 16) | 32'h040);
        run_frame();
        check(log_n == 1 && log_pal[0] == 1'b1, "R5 palette request", log_pal[0], 1);
        check(log_len[0] == 12'h040, "R5 palette length", log_len[0], 12'h040);
        reg_read(2'd1, d);
        check(d == 0, "R5 no frame bits on palette", d, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        clear_all();
        ch_active = '0;
        set_ch(1, 1, 32'h1000_0000, 32'h10);
        reg_write(2'd2, 32'h2);
        run_frame();
        check(irq == 1'b1, "R10 irq after pass", irq, 1);
        reg_write(2'd1, 32'h2);
        check(irq == 1'b0, "R10 irq drops after clear", irq, 0);
        reg_read(2'd1, d);
        check(d == 32'h20, "R11 only written bit cleared", d, 32'h20);
        reg_write(2'd2, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        clear_all();
        ch_active = '0;
        set_ch(0, 1, 32'h1000_0000, 32'h10);
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1;
        @(negedge clk); reg_wr = 1'b0;
        repeat (20) @(negedge clk);
        reg_read(2'd1, d);
        check(d[0] == 1'b1, "R11 set wins over clear", d[0], 1);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        clear_all();
        ch_active = '0;
        set_ch(0, 1, 32'h1000_0000, 32'h10);
        reg_write(2'd0, 32'h3);
        run_frame();
        check(log_n == 1, "R9 last frame still fetched", log_n, 1);
        reg_read(2'd0, d);
        check(d[1:0] == 2'b10, "R9 enable cleared", d[1:0], 2'b10);
        reg_read(2'd1, d);
        check(d[12] == 1'b1, "R9 done bit set", d[12], 1);
        log_n = 0;
        run_frame();
        check(log_n == 0, "R1 no pass after disable", log_n, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_order();
        t_berr();
        t_reparse();
        t_palette();
        t_irq();
        t_collide();
        t_disable();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule